// File: doc/BRIEF.md
# Credit-Based DMA Channel Flow Control

This block sits inside a DMA controller and decides when each channel may move one burst to or from its peripheral FIFO. The peripheral reports nothing except a single-cycle pulse per word that it takes from or puts into a channel's FIFO. It sends no level and no threshold. For each channel the engine therefore keeps its own picture of the peripheral FIFO. It uses a programmed FIFO size, which must equal the real depth of that channel's slice of the peripheral's shared buffer, and a programmed burst length.

Each channel holds a level counter, and the empty state is zero in both directions. On a transmit channel the level counts words in flight: a granted burst adds the burst length, and each peripheral read pulse removes one word. The channel is ready when the level plus the burst length does not exceed the FIFO size. On a receive channel the level counts data words waiting: each peripheral write pulse adds one word, and a completed burst removes the burst length. The channel is ready when the level is at least the burst length.

A two-state controller serves one burst at a time. In IDLE, a round-robin arbiter picks one ready channel; that is the transition "grant", and the controller moves to BUSY. In BUSY, the burst request stays asserted with the channel number held until burst completion; that is the transition "complete", and the controller returns to IDLE.

Top module: `fc_engine`

## Requirements
- R1: After reset, every level is zero, every error flag is low and no burst request is asserted. A transmit channel is therefore ready exactly when it is enabled and its burst length is nonzero and no larger than its FIFO size. A receive channel is not ready.
- R2: On a transmit channel (`ch_is_tx` bit = 1), a grant adds the burst length to the level and each `word_pulse` removes 1. The channel is ready when it is enabled, the burst length is nonzero and level + burst length ≤ FIFO size.
- R3: On a receive channel (`ch_is_tx` bit = 0), each `word_pulse` adds 1 to the level and `burst_done` for that channel's burst removes the burst length. The channel is ready when it is enabled, the burst length is nonzero and level ≥ burst length.
- R4: A word pulse and a grant or completion on the same channel in the same cycle are applied together as one net change.
- R5: If a net change would take the level below 0 or above the FIFO size, the level saturates at that bound and the channel's error flag goes high and stays high until reset.
- R6: While a channel is disabled, or in any cycle in which its `ch_size_wr` bit is high, its level is forced to zero and its word pulses are ignored.
- R7: In IDLE, a grant to a ready channel moves the controller to BUSY. In the next cycle `burst_req` rises with `burst_ch` naming that channel. Both hold until a cycle with `burst_done` high, and then the controller returns to IDLE. `burst_done` in IDLE has no effect.
- R8: When several channels are ready, the grant goes to the first ready channel in increasing index order (wrapping) after the most recently granted one. After reset the search starts at channel 0.
- R9: Each channel uses its own FIFO size and burst length, so different channels may hold different depths at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ch_en | input | NCH | Channel enables |
| ch_is_tx | input | NCH | 1 = memory-to-peripheral, 0 = peripheral-to-memory |
| ch_fifo_size | input | NCH*CW | Mirrored peripheral FIFO depth, channel i at [i*CW +: CW] |
| ch_burst_len | input | NCH*CW | Burst length in words, same packing |
| ch_size_wr | input | NCH | Pulse when a channel's size register is written |
| word_pulse | input | NCH | One pulse per word the peripheral reads or writes |
| burst_done | input | 1 | The burst in service has completed |
| burst_req | output | 1 | A burst is requested (BUSY) |
| burst_ch | output | CHW | Channel of the requested burst |
| ch_ready | output | NCH | Channel has room or data for a burst |
| ch_err | output | NCH | Sticky level range error |

## Verification
The bench builds the engine with four channels and a five-bit counter width, so FIFO sizes up to 31 words are possible. This small size lets saturation at both bounds happen within a few pulses. Directed phases first mix directions and sizes, including a transmit channel whose burst is larger than its FIFO and so is never ready. Random phases then regularly rewrite sizes, burst lengths and directions, and that reaches the reinit-during-service and coincident pulse-with-grant cases. With four channels ready at once, the arbiter has to wrap its pointer in both the directed and the random phases.

// File: rtl/fc_pkg.sv
package fc_pkg;
    typedef enum logic {
        FC_IDLE = 1'b0,
        FC_BUSY = 1'b1
    } fc_state_e;
endpackage

// File: rtl/fc_level_ctr.sv
module fc_level_ctr #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          is_tx,
    input  logic [CW-1:0] fifo_size,
    input  logic [CW-1:0] burst_len,
    input  logic          size_wr,
    input  logic          word_pulse,
    input  logic          issue,
    input  logic          done,
    output logic          ready,
    output logic          err
);
    localparam int SW = CW + 2;

    logic [CW-1:0]        lvl_q;
    logic signed [SW-1:0] lvl_s, size_s, burst_s, up_s, dn_s, sum_s;
    logic                 under, over;

    always_comb begin
        lvl_s   = $signed({2'b00, lvl_q});
        size_s  = $signed({2'b00, fifo_size});
        burst_s = $signed({2'b00, burst_len});
        up_s    = '0;
        dn_s    = '0;
        if (is_tx) begin
            if (issue)      up_s = burst_s;
            if (word_pulse) dn_s = SW'(1);
        end else begin
            if (word_pulse) up_s = SW'(1);
            if (done)       dn_s = burst_s;
        end
        sum_s = lvl_s + up_s - dn_s;
        under = sum_s < 0;
        over  = sum_s > size_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= '0;
            err   <= 1'b0;
        end else if (!en || size_wr) begin
            lvl_q <= '0;
        end else begin
            if (under)     lvl_q <= '0;
            else if (over) lvl_q <= fifo_size;
            else           lvl_q <= sum_s[CW-1:0];
            if (under || over) err <= 1'b1;
        end
    end

    always_comb begin
        ready = en && (burst_len != '0) &&
                (is_tx ? (lvl_s + burst_s <= size_s) : (lvl_s >= burst_s));
    end

    // R5
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    // R5
    level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !size_wr) |=> (size_wr || lvl_q <= fifo_size));

    // R6
    reinit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en || size_wr) |=> (lvl_q == '0));
endmodule

// File: rtl/fc_rr_arb.sv
module fc_rr_arb #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          advance,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] gnt_idx
);
    logic [IW-1:0] last_q;
    logic [IW-1:0] cand;
    logic          found;

    always_comb begin
        gnt     = '0;
        gnt_idx = '0;
        found   = 1'b0;
        cand    = '0;
        for (int k = 1; k <= N; k++) begin
            cand = IW'((int'(last_q) + k) % N);
            if (!found && req[cand]) begin
                found        = 1'b1;
                gnt_idx      = cand;
                gnt[cand]    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 last_q <= IW'(N - 1);
        else if (advance && found)  last_q <= gnt_idx;
    end

    // R8
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    // R8
    grant_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0);
endmodule

// File: rtl/fc_engine.sv
module fc_engine
    import fc_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = 8,
    parameter int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    ch_en,
    input  logic [NCH-1:0]    ch_is_tx,
    input  logic [NCH*CW-1:0] ch_fifo_size,
    input  logic [NCH*CW-1:0] ch_burst_len,
    input  logic [NCH-1:0]    ch_size_wr,
    input  logic [NCH-1:0]    word_pulse,
    input  logic              burst_done,
    output logic              burst_req,
    output logic [CHW-1:0]    burst_ch,
    output logic [NCH-1:0]    ch_ready,
    output logic [NCH-1:0]    ch_err
);
    fc_state_e      state_q, state_d;
    logic [CHW-1:0] ch_q;
    logic [NCH-1:0] gnt, issue_vec, done_vec;
    logic [CHW-1:0] gnt_idx;
    logic           in_idle;

    assign in_idle = (state_q == FC_IDLE);

    fc_rr_arb #(.N(NCH), .IW(CHW)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (ch_ready),
        .advance (in_idle),
        .gnt     (gnt),
        .gnt_idx (gnt_idx)
    );

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            assign issue_vec[i] = in_idle && gnt[i];
            assign done_vec[i]  = (state_q == FC_BUSY) && burst_done && (ch_q == CHW'(i));
            fc_level_ctr #(.CW(CW)) u_ctr (
                .clk        (clk),
                .rst_n      (rst_n),
                .en         (ch_en[i]),
                .is_tx      (ch_is_tx[i]),
                .fifo_size  (ch_fifo_size[i*CW +: CW]),
                .burst_len  (ch_burst_len[i*CW +: CW]),
                .size_wr    (ch_size_wr[i]),
                .word_pulse (word_pulse[i]),
                .issue      (issue_vec[i]),
                .done       (done_vec[i]),
                .ready      (ch_ready[i]),
                .err        (ch_err[i])
            );
        end
    endgenerate

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FC_IDLE: if (|gnt)      state_d = FC_BUSY;
            FC_BUSY: if (burst_done) state_d = FC_IDLE;
            default:                 state_d = FC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FC_IDLE;
            ch_q    <= '0;
        end else begin
            state_q <= state_d;
            if (in_idle && |gnt) ch_q <= gnt_idx;
        end
    end

    always_comb begin
        burst_req = (state_q == FC_BUSY);
        burst_ch  = ch_q;
    end

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_req && !burst_done) |=> (burst_req && $stable(burst_ch)));

    // R7
    idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_req && burst_done) |=> !burst_req);

    // R7
    grant_raises_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!burst_req && |ch_ready) |=> burst_req);
endmodule

// File: tb/tb_fc_engine.sv
module tb_fc_engine;
    localparam int NCH = 4;
    localparam int CW  = 5;
    localparam int CHW = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH-1:0]    en = '0, tx = '0, size_wr = '0, pulse = '0;
    logic [NCH*CW-1:0] fsize = '0, blen = '0;
    logic              burst_done = 1'b0;
    logic              burst_req;
    logic [CHW-1:0]    burst_ch;
    logic [NCH-1:0]    ch_ready, ch_err;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int m_lvl [NCH];
    bit m_err [NCH];
    bit m_busy;
    int m_ch;
    int m_last;

    always #5 clk = ~clk;

    fc_engine #(.NCH(NCH), .CW(CW), .CHW(CHW)) dut (
        .clk(clk), .rst_n(rst_n), .ch_en(en), .ch_is_tx(tx),
        .ch_fifo_size(fsize), .ch_burst_len(blen), .ch_size_wr(size_wr),
        .word_pulse(pulse), .burst_done(burst_done), .burst_req(burst_req),
        .burst_ch(burst_ch), .ch_ready(ch_ready), .ch_err(ch_err)
    );

    function automatic int sz(int i);
        return int'(fsize[i*CW +: CW]);
    endfunction

    function automatic int bl(int i);
        return int'(blen[i*CW +: CW]);
    endfunction

    function automatic bit m_ready(int i);
        if (!en[i] || bl(i) == 0) return 0;
        if (tx[i]) return (m_lvl[i] + bl(i) <= sz(i));
        return (m_lvl[i] >= bl(i));
    endfunction

    function automatic int m_pick();
        for (int k = 1; k <= NCH; k++) begin
            int c = (m_last + k) % NCH;
            if (m_ready(c)) return c;
        end
        return -1;
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        logic [NCH-1:0] er, ee;
        for (int i = 0; i < NCH; i++) begin
            er[i] = m_ready(i);
            ee[i] = m_err[i];
        end
        check(tag, "ready", int'(ch_ready), int'(er));
        check(tag, "err", int'(ch_err), int'(ee));
        check(tag, "req", int'(burst_req), int'(m_busy));
        if (m_busy) check(tag, "burst_ch", int'(burst_ch), m_ch);
    endtask

    task automatic model_reset();
        for (int i = 0; i < NCH; i++) begin
            m_lvl[i] = 0;
            m_err[i] = 0;
        end
        m_busy = 0;
        m_ch   = 0;
        m_last = NCH - 1;
    endtask

    task automatic step(input string tag);
        int g;
        int nl [NCH];
        bit ne [NCH];
        bit nb;
        int nc, nlast;
        g = m_busy ? -1 : m_pick();
        nb = m_busy; nc = m_ch; nlast = m_last;
        if (g >= 0) begin nb = 1; nc = g; nlast = g; end
        else if (m_busy && burst_done) nb = 0;
        for (int i = 0; i < NCH; i++) begin
            ne[i] = m_err[i];
            if (!en[i] || size_wr[i]) nl[i] = 0;
            else begin
                int n = m_lvl[i];
                if (tx[i]) begin
                    if (g == i) n += bl(i);
                    if (pulse[i]) n -= 1;
                end else begin
                    if (pulse[i]) n += 1;
                    if (m_busy && burst_done && m_ch == i) n -= bl(i);
                end
                if (n < 0) begin n = 0; ne[i] = 1; end
                else if (n > sz(i)) begin n = sz(i); ne[i] = 1; end
                nl[i] = n;
            end
        end
        @(posedge clk);
        for (int i = 0; i < NCH; i++) begin m_lvl[i] = nl[i]; m_err[i] = ne[i]; end
        m_busy = nb; m_ch = nc; m_last = nlast;
        @(negedge clk);
        compare(tag);
        pulse = '0; size_wr = '0; burst_done = 1'b0;
    endtask

    task automatic cfg(input int i, input bit t, input int s, input int b);
        tx[i] = t;
        fsize[i*CW +: CW] = CW'(s);
        blen[i*CW +: CW]  = CW'(b);
        size_wr[i] = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        tx = 4'b0101;
        fsize = {5'd12, 5'd6, 5'd16, 5'd8};
        blen  = {5'd2, 5'd8, 5'd4, 5'd4};
        en = 4'b0101;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state; ch0 ready, ch2 burst larger than FIFO
        compare("R1");
        check("R1", "req_after_reset", int'(burst_req), 0);
        check("R1", "ready_after_reset", int'(ch_ready), 1);

        // R2 and R7: transmit credit, held request until done
        en = 4'b0001;
        for (int k = 0; k < 14; k++) begin
            burst_done = (k % 4 == 3);
            pulse[0] = (k > 6);
            step("R2");
        end
        // R7: done while idle has no effect
        for (int k = 0; k < 4; k++) begin
            burst_done = !burst_req;
            step("R7");
        end
        // R4: pulse coincident with grant and completion
        en = 4'b1011;
        for (int k = 0; k < 16; k++) begin
            pulse = 4'b1011;
            burst_done = (k % 2 == 1);
            step("R4");
        end
        // R3: receive fill and drain
        for (int k = 0; k < 12; k++) begin
            pulse[1] = (k < 6);
            burst_done = (k % 3 == 2);
            step("R3");
        end
        // R5: transmit underflow and receive overflow saturate with sticky error
        en = '0; step("R6");
        en = 4'b0001;
        pulse[0] = 1'b1; step("R5");
        pulse[0] = 1'b1; step("R5");
        en = 4'b1000;
        for (int k = 0; k < 16; k++) begin
            pulse[3] = 1'b1;
            step("R5");
        end
        check("R5", "err_ch3", int'(ch_err[3]), 1);
        // R6: disabled pulses ignored, size write clears
        en = 4'b0000;
        for (int k = 0; k < 5; k++) begin pulse[1] = 1'b1; step("R6"); end
        check("R6", "ch1_not_ready", int'(ch_ready[1]), 0);
        en = 4'b0010;
        for (int k = 0; k < 3; k++) begin pulse[1] = 1'b1; step("R6"); end
        cfg(1, 0, 16, 4); pulse[1] = 1'b1; step("R6");
        pulse[1] = 1'b1; step("R6");
        check("R6", "ch1_after_clear", int'(ch_ready[1]), 0);
        // R8: all receive, all ready, rotating grants
        en = 4'b0000; step("R8");
        for (int i = 0; i < NCH; i++) cfg(i, 0, 16, 2);
        en = 4'b1111;
        step("R8");
        for (int k = 0; k < 24; k++) begin
            pulse = (k < 8) ? 4'b1111 : 4'b0000;
            burst_done = burst_req;
            step("R8");
        end
        // R9: distinct sizes per channel
        cfg(0, 1, 3, 3); cfg(1, 0, 20, 5); cfg(2, 1, 10, 5); cfg(3, 0, 7, 1);
        for (int k = 0; k < 60; k++) begin
            pulse = 4'($urandom);
            burst_done = burst_req && ($urandom % 2 == 0);
            step("R9");
        end
        // Random mix
        for (int k = 0; k < 4000; k++) begin
            pulse = 4'($urandom & $urandom);
            burst_done = burst_req && ($urandom % 3 == 0);
            if ($urandom % 60 == 0) begin
                int c = int'($urandom % NCH);
                cfg(c, 1'($urandom), int'($urandom % 32), int'($urandom % 12));
            end
            if ($urandom % 150 == 0) en[$urandom % NCH] ^= 1'b1;
            step("R2 R3 R4 R5 R8");
        end
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule